// File: doc/BRIEF.md
# Charge Status LED Pattern Driver

This block drives the two status indicators of a two-cell charger. Each indicator is an open-drain pin that the block either pulls low or leaves floating; it is never driven high. What an indicator shows depends on the charge activity of the cell it reports (no battery, charging, maintenance, fault) and on a display mode picked by a board strap. The blink patterns are built from a sub-tick of 0.16 s. The block also derives the 0.96 s main timebase of the charger as exactly six sub-ticks.

The second indicator pin also serves as a configuration strap. Right after reset the block runs a short probe on that pin and on the display-mode pin, applying first a source test current and then a sink test current. Together, the two readings of each pin tell low, open and high apart. The second pin yields the charge mode: one-cell series, two-cell series or parallel. The display-mode pin yields one of three display modes. The indicators stay floating until the probe is complete. After that, the blink phase of each indicator restarts whenever the activity it shows changes.

The probe runs through three named states. PROBE_SOURCE applies the source current for `TEST_CYCLES` cycles and then takes the transition *source done* to PROBE_SINK. PROBE_SINK applies the sink current for `TEST_CYCLES` cycles and then takes the transition *decode* to ACTIVE. ACTIVE is held until reset.

Top module: `cell_status_led_drv`

## Requirements
- R1: An indicator whose shown activity is no battery (code 0) floats (sink output 0) in every display mode. The sink outputs only ever request pull-low (1) or float (0).
- R2: Fault (activity code 3) blinks one slot low, then one slot floating, repeating, in every display mode.
- R3: Charging (code 1) and maintenance (code 2) use a per-mode table. Display mode 0 shows charging steady low and maintenance as 5 slots low then 1 floating. Display mode 1 shows charging as 3 slots low then 3 floating, and maintenance steady low. Display mode 2 shows charging as 5 low then 1 floating, and maintenance as 3 low then 3 floating.
- R4: The second indicator pin strapped low, open or high gives `charge_mode` 0 (one-cell series), 1 (two-cell series) or 2 (parallel). The value is held from `cfg_valid` onward.
- R5: The display-mode pin strapped low, open or high selects display mode 0, 1 or 2.
- R6: After reset, `test_src_en` is high for `TEST_CYCLES` cycles, and then `test_snk_en` is high for `TEST_CYCLES` cycles. The two are never high together. `cfg_valid` rises on the next cycle, and both indicators float until it does. A pin that reads 1 under the source current and 0 under the sink current is decoded as open; a pin that reads 1 under both is decoded as high; any other pair of readings is decoded as low.
- R7: In series modes the second indicator floats. In one-cell series the first indicator shows cell 1. In two-cell series it shows the more urgent activity of the two cells, with fault ranked above charging, charging above maintenance, and maintenance above no battery.
- R8: In parallel mode, indicator 1 shows cell 1 and indicator 2 shows cell 2, independently.
- R9: Every pattern slot lasts `SUB_CYCLES` clock cycles, and a pattern repeats every 6 slots.
- R10: A change of shown activity restarts that indicator at slot 0 on the next clock edge, even when the edge coincides with a slot boundary.
- R11: `base_tick` is high for one cycle in every 6·`SUB_CYCLES` cycles. Counting edges since reset, it is high after edge 6·`SUB_CYCLES`−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cell1_act | input | 2 | Cell 1 activity: 0 none, 1 charging, 2 maintenance, 3 fault |
| cell2_act | input | 2 | Cell 2 activity, same encoding |
| strap_lvl | input | 1 | Sampled level of the second indicator pin |
| dsel_lvl | input | 1 | Sampled level of the display-mode pin |
| test_src_en | output | 1 | Source test current request for both strap pins |
| test_snk_en | output | 1 | Sink test current request for both strap pins |
| cfg_valid | output | 1 | Probe finished, indicators active |
| charge_mode | output | 2 | Decoded charge mode |
| base_tick | output | 1 | One-cycle pulse each 0.96 s (six sub-ticks) |
| led1_sink | output | 1 | 1 pulls indicator 1 low, 0 floats it |
| led2_sink | output | 1 | 1 pulls indicator 2 low, 0 floats it |

## Verification
Two things can fall in the same clock edge: a lane's own slot advance and a restart caused by a change of shown activity. The bench provokes this on purpose. It switches cell 1 from charging to fault so that the change reaches the design at exactly the edge where the charging pattern would move to slot 1. It then expects the fault blink to begin at slot 0 (low), followed by a floating slot `SUB_CYCLES` cycles later. A design that lets the advance win would show the floating slot first. Random activity pairs under all nine strap combinations cover the rest of the pattern table and the series merge.

// File: rtl/csl_pkg.sv
package csl_pkg;

    localparam int PHASES  = 6;
    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_CHG   = 2'd1,
        ACT_MAINT = 2'd2,
        ACT_FAULT = 2'd3
    } activity_e;

    typedef enum logic [1:0] {
        CM_ONE_SER  = 2'd0,
        CM_TWO_SER  = 2'd1,
        CM_PARALLEL = 2'd2
    } charge_mode_e;

    typedef enum logic [1:0] {
        DM_0 = 2'd0,
        DM_1 = 2'd1,
        DM_2 = 2'd2
    } dispmode_e;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'd0,
        STRAP_OPEN = 2'd1,
        STRAP_HIGH = 2'd2
    } strap_e;

    typedef enum logic [2:0] {
        PAT_OFF,
        PAT_STEADY,
        PAT_SLOW,
        PAT_HALF,
        PAT_QUICK
    } pattern_e;

    function automatic strap_e strap_from_levels(input logic up_lvl, input logic dn_lvl);
        if (up_lvl && dn_lvl)        return STRAP_HIGH;
        else if (up_lvl && !dn_lvl)  return STRAP_OPEN;
        else                         return STRAP_LOW;
    endfunction

    function automatic activity_e more_urgent(input activity_e a, input activity_e b);
        if (a == ACT_FAULT || b == ACT_FAULT)      return ACT_FAULT;
        else if (a == ACT_CHG || b == ACT_CHG)     return ACT_CHG;
        else if (a == ACT_MAINT || b == ACT_MAINT) return ACT_MAINT;
        else                                       return ACT_NONE;
    endfunction

    function automatic pattern_e pattern_for(input dispmode_e dm, input activity_e act);
        pattern_e p;
        p = PAT_OFF;
        unique case (act)
            ACT_NONE:  p = PAT_OFF;
            ACT_FAULT: p = PAT_QUICK;
            ACT_CHG: begin
                unique case (dm)
                    DM_0:    p = PAT_STEADY;
                    DM_1:    p = PAT_HALF;
                    default: p = PAT_SLOW;
                endcase
            end
            ACT_MAINT: begin
                unique case (dm)
                    DM_0:    p = PAT_SLOW;
                    DM_1:    p = PAT_STEADY;
                    default: p = PAT_HALF;
                endcase
            end
        endcase
        return p;
    endfunction

    function automatic logic pattern_low(input pattern_e p, input logic [PHASE_W-1:0] ph);
        logic v;
        v = 1'b0;
        unique case (p)
            PAT_OFF:    v = 1'b0;
            PAT_STEADY: v = 1'b1;
            PAT_SLOW:   v = (ph < 3'd5);
            PAT_HALF:   v = (ph < 3'd3);
            PAT_QUICK:  v = ~ph[0];
            default:    v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/csl_strap_probe.sv
module csl_strap_probe
    import csl_pkg::*;
#(
    parameter int TEST_CYCLES = 625000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_lvl,
    input  logic         dsel_lvl,
    output logic         test_src_en,
    output logic         test_snk_en,
    output logic         cfg_valid,
    output charge_mode_e mode,
    output dispmode_e    dmode
);

    localparam int CW = (TEST_CYCLES > 1) ? $clog2(TEST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TEST_CYCLES - 1);

    typedef enum logic [1:0] {
        PROBE_SOURCE,
        PROBE_SINK,
        ACTIVE
    } probe_state_e;

    probe_state_e  state, nxt;
    logic [CW-1:0] cnt;
    logic          up_strap, up_dsel;
    strap_e        strap_dec, dsel_dec;
    logic          last;

    assign last      = (cnt == CNT_LAST);
    assign strap_dec = strap_from_levels(up_strap, strap_lvl);
    assign dsel_dec  = strap_from_levels(up_dsel, dsel_lvl);

    always_comb begin
        nxt = state;
        unique case (state)
            PROBE_SOURCE: if (last) nxt = PROBE_SINK;
            PROBE_SINK:   if (last) nxt = ACTIVE;
            ACTIVE:       nxt = ACTIVE;
            default:      nxt = PROBE_SOURCE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PROBE_SOURCE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state != nxt)
                cnt <= '0;
            else if (state != ACTIVE)
                cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_strap <= 1'b0;
            up_dsel  <= 1'b0;
            mode     <= CM_ONE_SER;
            dmode    <= DM_0;
        end else begin
            if (state == PROBE_SOURCE && last) begin
                up_strap <= strap_lvl;
                up_dsel  <= dsel_lvl;
            end
            if (state == PROBE_SINK && last) begin
                unique case (strap_dec)
                    STRAP_LOW:  mode <= CM_ONE_SER;
                    STRAP_OPEN: mode <= CM_TWO_SER;
                    default:    mode <= CM_PARALLEL;
                endcase
                unique case (dsel_dec)
                    STRAP_LOW:  dmode <= DM_0;
                    STRAP_OPEN: dmode <= DM_1;
                    default:    dmode <= DM_2;
                endcase
            end
        end
    end

    always_comb begin
        test_src_en = 1'b0;
        test_snk_en = 1'b0;
        cfg_valid   = 1'b0;
        unique case (state)
            PROBE_SOURCE: test_src_en = 1'b1;
            PROBE_SINK:   test_snk_en = 1'b1;
            ACTIVE:       cfg_valid   = 1'b1;
            default:      cfg_valid   = 1'b0;
        endcase
    end

endmodule

// File: rtl/csl_timebase.sv
module csl_timebase
    import csl_pkg::*;
#(
    parameter int SUB_CYCLES = 20000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic base_tick
);

    localparam int SW = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1;
    localparam logic [SW-1:0]      SUB_LAST  = SW'(SUB_CYCLES - 1);
    localparam logic [PHASE_W-1:0] SLOT_LAST = PHASE_W'(PHASES - 1);

    logic [SW-1:0]      sub_cnt;
    logic [PHASE_W-1:0] slot_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_cnt  <= '0;
            slot_cnt <= '0;
        end else if (sub_cnt == SUB_LAST) begin
            sub_cnt  <= '0;
            slot_cnt <= (slot_cnt == SLOT_LAST) ? '0 : slot_cnt + 1'b1;
        end else begin
            sub_cnt <= sub_cnt + 1'b1;
        end
    end

    assign base_tick = (sub_cnt == SUB_LAST) && (slot_cnt == SLOT_LAST);

endmodule

// File: rtl/csl_blink_lane.sv
module csl_blink_lane
    import csl_pkg::*;
#(
    parameter int SUB_CYCLES = 20000000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  activity_e act_in,
    input  dispmode_e dm,
    output logic      sink
);

    localparam int SW = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1;
    localparam logic [SW-1:0]      SUB_LAST  = SW'(SUB_CYCLES - 1);
    localparam logic [PHASE_W-1:0] SLOT_LAST = PHASE_W'(PHASES - 1);

    activity_e          act_q;
    logic [SW-1:0]      cyc;
    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= ACT_NONE;
            cyc   <= '0;
            phase <= '0;
        end else if (!run) begin
            act_q <= ACT_NONE;
            cyc   <= '0;
            phase <= '0;
        end else if (act_in != act_q) begin
            act_q <= act_in;
            cyc   <= '0;
            phase <= '0;
        end else if (cyc == SUB_LAST) begin
            cyc   <= '0;
            phase <= (phase == SLOT_LAST) ? '0 : phase + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    always_comb begin
        sink = run && pattern_low(pattern_for(dm, act_q), phase);
    end

endmodule

// File: rtl/cell_status_led_drv.sv
module cell_status_led_drv
    import csl_pkg::*;
#(
    parameter int SUB_CYCLES  = 20000000,
    parameter int TEST_CYCLES = 625000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cell1_act,
    input  logic [1:0] cell2_act,
    input  logic       strap_lvl,
    input  logic       dsel_lvl,
    output logic       test_src_en,
    output logic       test_snk_en,
    output logic       cfg_valid,
    output logic [1:0] charge_mode,
    output logic       base_tick,
    output logic       led1_sink,
    output logic       led2_sink
);

    localparam int LANES = 2;

    charge_mode_e mode;
    dispmode_e    dmode;
    activity_e    a1, a2;
    activity_e    lane_act [LANES];
    logic [LANES-1:0] lane_sink;

    csl_strap_probe #(.TEST_CYCLES(TEST_CYCLES)) probe_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_lvl   (strap_lvl),
        .dsel_lvl    (dsel_lvl),
        .test_src_en (test_src_en),
        .test_snk_en (test_snk_en),
        .cfg_valid   (cfg_valid),
        .mode        (mode),
        .dmode       (dmode)
    );

    csl_timebase #(.SUB_CYCLES(SUB_CYCLES)) tb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick)
    );

    assign a1 = activity_e'(cell1_act);
    assign a2 = activity_e'(cell2_act);

    always_comb begin
        unique case (mode)
            CM_ONE_SER: begin
                lane_act[0] = a1;
                lane_act[1] = ACT_NONE;
            end
            CM_TWO_SER: begin
                lane_act[0] = more_urgent(a1, a2);
                lane_act[1] = ACT_NONE;
            end
            default: begin
                lane_act[0] = a1;
                lane_act[1] = a2;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        csl_blink_lane #(.SUB_CYCLES(SUB_CYCLES)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (cfg_valid),
            .act_in (lane_act[g]),
            .dm     (dmode),
            .sink   (lane_sink[g])
        );
    end

    assign charge_mode = mode;
    assign led1_sink   = lane_sink[0];
    assign led2_sink   = lane_sink[1];

endmodule

// File: rtl/csl_checker.sv
module csl_checker #(
    parameter int SUB_CYCLES = 20000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cell1_act,
    input logic [1:0] cell2_act,
    input logic       test_src_en,
    input logic       test_snk_en,
    input logic       cfg_valid,
    input logic [1:0] charge_mode,
    input logic       base_tick,
    input logic       led1_sink,
    input logic       led2_sink
);

    localparam logic [31:0] PERIOD_LAST = 32'(6 * SUB_CYCLES - 1);

    logic [31:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         gap <= '0;
        else if (base_tick) gap <= '0;
        else                gap <= gap + 1'b1;
    end

    // R6: the two test currents never overlap
    p_test_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_src_en && test_snk_en));

    // R6: indicators float while the strap probe runs
    p_float_probe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (!led1_sink && !led2_sink));

    // R4: decoded mode and valid flag hold once set
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (cfg_valid && $stable(charge_mode)));

    // R7: second indicator floats in series modes
    p_series_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && charge_mode != 2'd2) |-> !led2_sink);

    // R1: no battery on a directly shown cell floats the indicator
    p_none_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && charge_mode != 2'd1 && cell1_act == 2'd0) |=> !led1_sink);

    // R11: base tick spacing
    p_tick_period_r11: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |-> (gap == PERIOD_LAST));

endmodule

bind cell_status_led_drv csl_checker #(.SUB_CYCLES(SUB_CYCLES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cell1_act   (cell1_act),
    .cell2_act   (cell2_act),
    .test_src_en (test_src_en),
    .test_snk_en (test_snk_en),
    .cfg_valid   (cfg_valid),
    .charge_mode (charge_mode),
    .base_tick   (base_tick),
    .led1_sink   (led1_sink),
    .led2_sink   (led2_sink)
);

// File: tb/cell_status_led_drv_tb.sv
module cell_status_led_drv_tb_top;

    localparam int SUB  = 4;
    localparam int TEST = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cell1_act = 2'd0;
    logic [1:0] cell2_act = 2'd0;
    logic       strap_lvl, dsel_lvl;
    logic       test_src_en, test_snk_en, cfg_valid, base_tick;
    logic       led1_sink, led2_sink;
    logic [1:0] charge_mode;

    int strap_led2 = 0;   // 0 low, 1 open, 2 high
    int strap_dsel = 0;
    int cur_cm = 0;
    int cur_dm = 0;
    int nchecks = 0;
    int nerr = 0;
    int edges = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign strap_lvl = (strap_led2 == 2) ? 1'b1 : (strap_led2 == 0) ? 1'b0 : test_src_en;
    assign dsel_lvl  = (strap_dsel == 2) ? 1'b1 : (strap_dsel == 0) ? 1'b0 : test_src_en;

    cell_status_led_drv #(.SUB_CYCLES(SUB), .TEST_CYCLES(TEST)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cell1_act   (cell1_act),
        .cell2_act   (cell2_act),
        .strap_lvl   (strap_lvl),
        .dsel_lvl    (dsel_lvl),
        .test_src_en (test_src_en),
        .test_snk_en (test_snk_en),
        .cfg_valid   (cfg_valid),
        .charge_mode (charge_mode),
        .base_tick   (base_tick),
        .led1_sink   (led1_sink),
        .led2_sink   (led2_sink)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %0b expected %0b (cm=%0d dm=%0d)", req, what, act, exp, cur_cm, cur_dm);
        end
    endtask

    function automatic int rank(input int a);
        case (a)
            3: return 3;
            1: return 2;
            2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int shown(input int lane, input int cm, input int a1, input int a2);
        if (lane == 1) return (cm == 2) ? a2 : 0;
        if (cm == 1) return (rank(a1) >= rank(a2)) ? a1 : a2;
        return a1;
    endfunction

    function automatic logic exp_sink(input int dm, input int act, input int p);
        case (act)
            0: return 1'b0;
            3: return (p % 2) == 0;
            1: return (dm == 0) ? 1'b1 : (dm == 1) ? (p < 3) : (p < 5);
            default: return (dm == 0) ? (p < 5) : (dm == 1) ? 1'b1 : (p < 3);
        endcase
    endfunction

    function automatic string tag(input int lane, input int cm, input int act);
        if (lane == 1) return (cm == 2) ? "R8" : "R7";
        if (cm == 1) return "R7";
        if (act == 0) return "R1";
        if (act == 3) return "R2";
        return "R3";
    endfunction

    // edge counter and R11 monitor
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (base_tick || (edges % (6 * SUB)) == 6 * SUB - 1)
                chk(base_tick, (edges % (6 * SUB)) == 6 * SUB - 1, "R11", "base_tick");
        end
    end

    task automatic configure(input int led2s, input int dsels);
        strap_led2 = led2s;
        strap_dsel = dsels;
        cur_cm = led2s;
        cur_dm = dsels;
        cell1_act = 2'd3;
        cell2_act = 2'd3;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(test_src_en, 1'b1, "R6", "src after reset");
        for (int i = 1; i <= 2 * TEST; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == TEST - 1 || i == TEST || i == 2 * TEST - 1 || i == 2 * TEST) begin
                chk(test_src_en, i < TEST, "R6", "src phase");
                chk(test_snk_en, (i >= TEST) && (i < 2 * TEST), "R6", "snk phase");
                chk(cfg_valid, i >= 2 * TEST, "R6", "cfg_valid");
            end
            if (i < 2 * TEST) begin
                chk(led1_sink, 1'b0, "R6", "led1 float in probe");
                chk(led2_sink, 1'b0, "R6", "led2 float in probe");
            end
        end
        nchecks++;
        if (charge_mode !== 2'(led2s)) begin
            nerr++;
            $display("FAIL R4 charge_mode: got %0d expected %0d", charge_mode, led2s);
        end
        cell1_act = 2'd0;
        cell2_act = 2'd0;
        @(negedge clk);
    endtask

    task automatic run_step(input int a1, input int a2, input string force_tag);
        int s1, s2;
        cell1_act = 2'd0;
        cell2_act = 2'd0;
        @(negedge clk);
        cell1_act = 2'(a1);
        cell2_act = 2'(a2);
        s1 = shown(0, cur_cm, a1, a2);
        s2 = shown(1, cur_cm, a1, a2);
        @(posedge clk);
        for (int p = 0; p <= 6; p++) begin
            @(negedge clk);
            chk(led1_sink, exp_sink(cur_dm, s1, p % 6),
                (p == 6) ? "R9" : (force_tag != "") ? force_tag : tag(0, cur_cm, s1), "led1 pattern");
            chk(led2_sink, (cur_cm == 2) ? exp_sink(cur_dm, s2, p % 6) : 1'b0,
                (p == 6) ? "R9" : tag(1, cur_cm, s2), "led2 pattern");
            if (p < 6) repeat (SUB) @(posedge clk);
        end
    endtask

    // R10: change arrives on the very edge of a slot boundary
    task automatic boundary_restart();
        cell1_act = 2'd0;
        cell2_act = 2'd0;
        @(negedge clk);
        cell1_act = 2'd1;
        @(posedge clk);
        @(negedge clk);
        repeat (SUB - 1) @(posedge clk);
        @(negedge clk);
        cell1_act = 2'd3;
        @(posedge clk);
        @(negedge clk);
        chk(led1_sink, 1'b1, "R10", "fault slot0 at boundary");
        repeat (SUB - 1) @(posedge clk);
        @(negedge clk);
        chk(led1_sink, 1'b1, "R10", "fault slot0 end");
        @(posedge clk);
        @(negedge clk);
        chk(led1_sink, 1'b0, "R10", "fault slot1");
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int cm = 0; cm < 3; cm++) begin
            for (int dm = 0; dm < 3; dm++) begin
                configure(cm, dm);
                run_step(1, 0, "R5");
                run_step(2, 0, "R5");
                run_step(3, 0, "");
                run_step(0, 3, "");
                for (int k = 0; k < 6; k++)
                    run_step(int'($urandom % 4), int'($urandom % 4), "");
                if (cm == 2) boundary_restart();
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchecks++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

endmodule